// File: doc/BRIEF.md
# Register-mapped SPI master controller

This block is a SPI master. It sits behind a simple word-addressed register port and drives SCK and MOSI and samples MISO. Software sets the character length, bit order, clock prescale and loopback in a mode register. It then writes one character into the transmit register, which starts the transfer. When the last clock period ends, the received character is placed right-justified in the receive register. The same edge raises the receive-ready and transmit-ready events.

The events are write-one-to-clear. A completion that arrives while receive-ready is still pending raises an overrun flag. The interrupt line is the OR of every event bit that the mask register enables. Chip selects, pin multiplexing and slave operation belong to other blocks.

Register word addresses: 0 mode, 1 event, 2 mask, 3 transmit, 4 receive. Read data is combinational from `addr_i` and has no side effects.

Top module: `spim_ctrl`

## Requirements
- R1: After reset every register reads zero, and `sck_o`, `mosi_o` and `irq_o` are low.
- R2: A transmit-register write starts a transfer only when the block is idle and mode bits 24 (enable) and 25 (master) are both set. Event bit 31 (busy) reads 1 from the write edge until the transfer ends. An N-bit character at prescale P ends exactly 4*(P+1)*N clock cycles after the write edge. At that edge busy clears, and the receive register and the events update.
- R3: Mode bits 23:20 select the character length. Value 0 gives 32 bits, values 3 to 15 give value+1 bits, and values 1 and 2 give 4 bits.
- R4: SCK idles low and has a period of 4*(P+1) clock cycles, where P is mode bits 19:16. MISO is sampled on the SCK rising edge. MOSI changes only at the start and on SCK falling edges.
- R5: The character is the low N bits of the transmit data. When mode bit 26 is 1, bit N-1 is sent first. When it is 0, bit 0 is sent first.
- R6: Received data is right-justified and zero above bit N-1. Each received bit lands in the position that the same order rule gives (MSB-first: first bit to N-1; LSB-first: first bit to 0).
- R7: When mode bit 30 is set, the receive shifter takes MOSI and ignores `miso_i`, so the receive register equals the low N transmit bits.
- R8: Completion sets event bit 9 (receive ready) and bit 8 (transmit ready). Writing 1 to an event bit clears it, writing 0 leaves it unchanged, and writing all ones clears every event.
- R9: A completion while bit 9 is still set overwrites the receive register and sets event bit 12 (overrun).
- R10: `irq_o` is the OR of event bits 12, 9 and 8, each ANDed with the same bit of the mask register. A zero mask keeps it low.
- R11: A transmit write while enable or master is clear, or while busy, is dropped. No transfer starts and the transmit register keeps its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register access select |
| we_i | input | 1 | Write enable |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| irq_o | output | 1 | Interrupt request |

## Verification
Register writes, event clears and the interrupt level change at the clock edge that takes the write. The bench therefore reads them back at the following falling edge. A transfer's results are due exactly 4*(P+1)*N cycles after its write edge. The bench counts that many falling edges and reads busy one cycle before the due edge, expecting 1. It then reads again right after the due edge and expects busy 0, the event pair set and the right receive value. SCK period and MOSI order are timed from SCK edges recorded during each transfer. A slave model shifts a known pattern onto MISO on each SCK fall.

// File: rtl/spim_pkg.sv
`timescale 1ns/1ps
package spim_pkg;
  localparam int A_MODE = 0;
  localparam int A_EV   = 1;
  localparam int A_MASK = 2;
  localparam int A_TX   = 3;
  localparam int A_RX   = 4;

  localparam int M_LOOP = 30;
  localparam int M_REV  = 26;
  localparam int M_MS   = 25;
  localparam int M_EN   = 24;
  localparam int M_LEN  = 20;
  localparam int M_PRE  = 16;
  localparam logic [31:0] MODE_WMASK = 32'h47FF_0000;

  localparam int E_BUSY = 31;
  localparam int E_OVR  = 12;
  localparam int E_NE   = 9;
  localparam int E_NF   = 8;
  localparam logic [31:0] MASK_WMASK = 32'h0000_1300;
endpackage

// File: rtl/spim_presc.sv
`timescale 1ns/1ps
module spim_presc #(
  parameter int PRE_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PRE_W-1:0] pre_i,
  output logic             tick_o
);
  localparam int CNT_W = PRE_W + 2;

  logic [PRE_W:0]   pre_p1;
  logic [CNT_W-1:0] half, cnt_q;

  assign pre_p1 = {1'b0, pre_i} + (PRE_W+1)'(1);
  assign half   = {pre_p1, 1'b0};
  assign tick_o = run_i && (cnt_q == half - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + CNT_W'(1);
  end

  p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < half));
endmodule

// File: rtl/spim_shift.sv
`timescale 1ns/1ps
module spim_shift #(
  parameter int DATA_W = 32,
  parameter int PRE_W  = 4,
  parameter int LEN_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [PRE_W-1:0]  pre_i,
  input  logic              rev_i,
  input  logic              loop_i,
  input  logic              miso_i,
  input  logic              tick_i,
  output logic              busy_o,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic [PRE_W-1:0]  pre_o
);
  localparam int IDX_W = $clog2(DATA_W);

  logic              busy_q, sck_q, rev_q, loop_q;
  logic [IDX_W-1:0]  idx_q, last_q, pos, last_d;
  logic [IDX_W:0]    nbits;
  logic [PRE_W-1:0]  pre_q;
  logic [DATA_W-1:0] txd_q, rxd_q;
  logic              at_last, miso_eff;

  // length field: 0 -> full width, 1..2 clamp to 4, else field+1
  always_comb begin
    if (len_i == '0)              nbits = (IDX_W+1)'(DATA_W);
    else if (len_i < LEN_W'(3))   nbits = (IDX_W+1)'(4);
    else                          nbits = (IDX_W+1)'(len_i) + (IDX_W+1)'(1);
    last_d = IDX_W'(nbits - (IDX_W+1)'(1));
  end

  assign pos      = rev_q ? (last_q - idx_q) : idx_q;
  assign at_last  = (idx_q == last_q);
  assign mosi_o   = busy_q & txd_q[pos];
  assign miso_eff = loop_q ? mosi_o : miso_i;
  assign done_o   = busy_q & tick_i & sck_q & at_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      idx_q  <= '0;
      last_q <= '0;
      rev_q  <= 1'b0;
      loop_q <= 1'b0;
      pre_q  <= '0;
      txd_q  <= '0;
      rxd_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      sck_q  <= 1'b0;
      idx_q  <= '0;
      last_q <= last_d;
      rev_q  <= rev_i;
      loop_q <= loop_i;
      pre_q  <= pre_i;
      txd_q  <= tx_data_i;
      rxd_q  <= '0;
    end else if (busy_q && tick_i) begin
      if (!sck_q) begin
        sck_q      <= 1'b1;
        rxd_q[pos] <= miso_eff;
      end else begin
        sck_q <= 1'b0;
        if (at_last) busy_q <= 1'b0;
        else         idx_q  <= idx_q + IDX_W'(1);
      end
    end
  end

  assign busy_o    = busy_q;
  assign sck_o     = sck_q;
  assign rx_data_o = rxd_q;
  assign pre_o     = pre_q;

  p_idle_sck_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !sck_q);
  p_mosi_on_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q) && !$fell(sck_q)) |-> $stable(mosi_o));
  p_end_after_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(sck_q));
  p_start_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
endmodule

// File: rtl/spim_regs.sv
`timescale 1ns/1ps
module spim_regs
  import spim_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PRE_W  = 4,
  parameter int LEN_W  = 4,
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic              start_o,
  output logic [DATA_W-1:0] tx_load_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [PRE_W-1:0]  pre_o,
  output logic              rev_o,
  output logic              loop_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] mode_q, mask_q, tx_q, rx_q, ev_rd, clr;
  logic              ne_q, nf_q, ovr_q, wr;

  assign wr        = sel_i & we_i;
  assign start_o   = wr && (addr_i == ADDR_W'(A_TX)) && mode_q[M_EN] && mode_q[M_MS] && !busy_i;
  assign tx_load_o = wdata_i;
  assign clr       = (wr && (addr_i == ADDR_W'(A_EV))) ? wdata_i : '0;

  assign len_o  = mode_q[M_LEN +: LEN_W];
  assign pre_o  = mode_q[M_PRE +: PRE_W];
  assign rev_o  = mode_q[M_REV];
  assign loop_o = mode_q[M_LOOP];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      mask_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      if (wr && addr_i == ADDR_W'(A_MODE)) mode_q <= wdata_i & MODE_WMASK;
      if (wr && addr_i == ADDR_W'(A_MASK)) mask_q <= wdata_i & MASK_WMASK;
      if (start_o) tx_q <= wdata_i;
      if (done_i)  rx_q <= rx_data_i;
    end
  end

  // completion wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ne_q  <= 1'b0;
      nf_q  <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      if (done_i)          ne_q  <= 1'b1;
      else if (clr[E_NE])  ne_q  <= 1'b0;
      if (done_i)          nf_q  <= 1'b1;
      else if (clr[E_NF])  nf_q  <= 1'b0;
      if (done_i && ne_q)  ovr_q <= 1'b1;
      else if (clr[E_OVR]) ovr_q <= 1'b0;
    end
  end

  always_comb begin
    ev_rd         = '0;
    ev_rd[E_BUSY] = busy_i;
    ev_rd[E_OVR]  = ovr_q;
    ev_rd[E_NE]   = ne_q;
    ev_rd[E_NF]   = nf_q;
  end

  assign irq_o = |({ovr_q, ne_q, nf_q} & {mask_q[E_OVR], mask_q[E_NE], mask_q[E_NF]});

  always_comb begin
    case (addr_i)
      ADDR_W'(A_MODE): rdata_o = mode_q;
      ADDR_W'(A_EV):   rdata_o = ev_rd;
      ADDR_W'(A_MASK): rdata_o = mask_q;
      ADDR_W'(A_TX):   rdata_o = tx_q;
      ADDR_W'(A_RX):   rdata_o = rx_q;
      default:         rdata_o = '0;
    endcase
  end

  p_ne_on_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> ne_q);
  p_overrun_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && ne_q) |=> ovr_q);
  p_masked_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> !irq_o);
  p_tx_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !start_o) |=> $stable(tx_q));
endmodule

// File: rtl/spim_ctrl.sv
`timescale 1ns/1ps
module spim_ctrl #(
  parameter int DATA_W = 32,
  parameter int PRE_W  = 4,
  parameter int LEN_W  = 4,
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              irq_o
);
  logic              start, busy, done, rev, loop, tick;
  logic [DATA_W-1:0] tx_load, rx_data;
  logic [LEN_W-1:0]  len;
  logic [PRE_W-1:0]  pre_cfg, pre_run;

  spim_regs #(.DATA_W(DATA_W), .PRE_W(PRE_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .sel_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .busy_i(busy), .done_i(done), .rx_data_i(rx_data),
    .start_o(start), .tx_load_o(tx_load), .len_o(len), .pre_o(pre_cfg),
    .rev_o(rev), .loop_o(loop), .irq_o
  );

  spim_presc #(.PRE_W(PRE_W)) u_presc (
    .clk_i, .rst_ni, .run_i(busy), .pre_i(pre_run), .tick_o(tick)
  );

  spim_shift #(.DATA_W(DATA_W), .PRE_W(PRE_W), .LEN_W(LEN_W)) u_shift (
    .clk_i, .rst_ni, .start_i(start), .tx_data_i(tx_load), .len_i(len),
    .pre_i(pre_cfg), .rev_i(rev), .loop_i(loop), .miso_i, .tick_i(tick),
    .busy_o(busy), .sck_o, .mosi_o, .done_o(done), .rx_data_o(rx_data),
    .pre_o(pre_run)
  );
endmodule

// File: tb/spim_ctrl_test.sv
`timescale 1ns/1ps
module spim_ctrl_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = '0, rdata;
  logic        sck, mosi, miso, irq;

  int total = 0, bad = 0;
  bit finished = 0;

  logic [31:0] pat = '0;
  logic [31:0] cap = '0;
  longint      rt [2];
  int k = 0, k0 = 0, ci = 0, ci0 = 0;

  always #2 clk = ~clk;

  spim_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .sck_o(sck), .mosi_o(mosi),
    .miso_i(miso), .irq_o(irq)
  );

  // slave model: next pattern bit after each SCK fall
  assign miso = pat[5'(k - k0)];
  always @(negedge sck) k = k + 1;
  always @(posedge sck) begin
    int j;
    j = ci - ci0;
    if (j >= 0 && j < 32) cap[j] = mosi;
    if (j >= 0 && j < 2) rt[j] = $time;
    ci = ci + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = 3'(a); wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic peek(input int a, output logic [31:0] d);
    addr = 3'(a);
    #1 d = rdata;
  endtask

  function automatic int nb(input int f);
    if (f == 0) return 32;
    if (f < 3) return 4;
    return f + 1;
  endfunction

  function automatic logic [31:0] mk(input bit lp, input bit rv, input bit ms, input bit en,
                                     input int f, input int p);
    return (32'(lp) << 30) | (32'(rv) << 26) | (32'(ms) << 25) | (32'(en) << 24) |
           (32'(f & 15) << 20) | (32'(p & 15) << 16);
  endfunction

  task automatic xfer(input int f, input int p, input bit rv, input bit lp,
                      input logic [31:0] txd, input logic [31:0] pv);
    int n, t;
    logic [31:0] d, m, erx, emo;
    n = nb(f);
    t = 4 * (p + 1) * n;
    m = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 1);
    wr(0, mk(lp, rv, 1'b1, 1'b1, f, p));
    wr(1, 32'hFFFF_FFFF);
    pat = pv; k0 = k; ci0 = ci;
    wr(3, txd);
    repeat (t - 1) @(negedge clk);
    peek(1, d);
    chk("R2 busy before due edge", 32'(d[31]), 32'd1);
    @(negedge clk);
    peek(1, d);
    chk("R2 R3 R8 events at due edge", d, 32'h0000_0300);
    erx = '0; emo = '0;
    for (int j = 0; j < n; j++) begin
      if (rv) begin erx[n-1-j] = pv[j]; emo[j] = txd[n-1-j]; end
      else    begin erx[j]     = pv[j]; emo[j] = txd[j];     end
    end
    if (lp) erx = txd & m;
    peek(4, d);
    chk(lp ? "R7 loopback receive" : "R6 receive placement", d, erx);
    chk("R5 mosi order", cap & m, emo);
    chk("R4 sck period", 32'(rt[1] - rt[0]), 32'(4 * (p + 1) * 4));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R2 watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 5; a++) begin
      peek(a, d);
      chk("R1 reset register", d, 32'd0);
    end
    chk("R1 reset pins", {29'd0, sck, mosi, irq}, 32'd0);

    // sweep lengths, order, loopback at prescale 0
    for (int f = 0; f < 16; f++)
      for (int rv = 0; rv < 2; rv++)
        for (int lp = 0; lp < 2; lp++)
          xfer(f, 0, rv[0], lp[0], 32'hA5C3_1E69 ^ (32'(f) * 32'h0101_0103),
               32'h3C96_F00D ^ (32'(f) << 7) ^ 32'(rv));
    // prescale sweep
    for (int p = 0; p < 16; p++)
      xfer(7, p, p[0], 1'b0, 32'(p * 37 + 5), 32'hB4 ^ 32'(p));

    // overrun
    wr(0, mk(1'b1, 1'b1, 1'b1, 1'b1, 7, 0));
    wr(1, 32'hFFFF_FFFF);
    wr(3, 32'h5A);
    repeat (40) @(negedge clk);
    wr(3, 32'hC3);
    repeat (40) @(negedge clk);
    peek(1, d);
    chk("R9 overrun flag", d, 32'h0000_1300);
    peek(4, d);
    chk("R9 receive overwritten", d, 32'hC3);

    // interrupt
    wr(2, 32'h200);
    chk("R10 irq ne enabled", 32'(irq), 32'd1);
    wr(1, 32'h200);
    chk("R10 irq after ne clear", 32'(irq), 32'd0);
    wr(2, 32'h1000);
    chk("R10 irq overrun enabled", 32'(irq), 32'd1);
    wr(2, 32'h0);
    chk("R10 irq mask zero", 32'(irq), 32'd0);
    wr(1, 32'hFFFF_FFFF);

    // dropped writes
    wr(0, mk(1'b1, 1'b1, 1'b1, 1'b0, 7, 0));
    wr(3, 32'h11);
    peek(1, d);
    chk("R11 disabled no start", d, 32'd0);
    peek(3, d);
    chk("R11 disabled tx kept", d, 32'hC3);
    wr(0, mk(1'b1, 1'b1, 1'b0, 1'b1, 7, 0));
    wr(3, 32'h22);
    peek(1, d);
    chk("R11 non-master no start", d, 32'd0);
    wr(0, mk(1'b1, 1'b1, 1'b1, 1'b1, 7, 1));
    wr(3, 32'h0F);
    wr(3, 32'hF0);
    peek(3, d);
    chk("R11 busy write tx kept", d, 32'h0F);
    repeat (70) @(negedge clk);
    peek(4, d);
    chk("R11 busy write dropped", d, 32'h0F);
    peek(1, d);
    chk("R11 single completion", d, 32'h0000_0300);

    // write-one-to-clear
    wr(1, 32'h100);
    peek(1, d);
    chk("R8 clear nf only", d, 32'h0000_0200);
    wr(1, 32'h0);
    peek(1, d);
    chk("R8 zero write keeps", d, 32'h0000_0200);
    wr(1, 32'hFFFF_FFFF);
    peek(1, d);
    chk("R8 clear all", d, 32'd0);
    chk("R4 sck idle low", 32'(sck), 32'd0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule